// File: doc/BRIEF.md
# Fixed-Point Narrowing Clip Unit

This block narrows a 64-bit word of packed wide elements into elements of half the width. Each wide element is shifted right by its own amount, rounded under one of four fixed-point rounding modes, and then either truncated (narrowing shifts) or clamped to the narrow range (signed or unsigned clips). The narrowed elements fill 32 bits, which land in either the lower or the upper half of the 64-bit result. A flag per lane reports that a clip clamped its value.

The unit is purely combinational: a vector lane drives the wide operand, the shift operand and the control fields, and reads the result and the flags in the same cycle. It has no internal states or transitions. All the work sits in one evaluation path: extend, shift, round, range check, pack.

Top module: `nclip_unit`

## Requirements
- R1: `op_i` selects the operation: 0 narrowing logical shift (source zero-extended), 1 narrowing arithmetic shift (source sign-extended), 2 unsigned clip (source unsigned), 3 signed clip (source signed). Wide lane i sits at bits [i*2S +: 2S] of `src_i`, where S is the narrow width.
- R2: `dw_i` selects the narrow width: 0 gives 8-bit results from four 16-bit sources, 1 gives 16-bit results from two 32-bit sources, 2 gives one 32-bit result from the 64-bit source. Code 3 is reserved and gives an all-zero result with all flags clear.
- R3: The shift amount of lane i is the low log2(2S) bits of the 2S-bit slot of `shamt_i` at the same position as source lane i. The upper bits of the slot are ignored.
- R4: `rm_i` selects the rounding increment added to the shifted value. 0 adds the bit just below the cut. 1 rounds to nearest with ties to even. 2 truncates. 3 forces the LSB to 1 when any discarded bit is set (round to odd). A shift of zero never rounds.
- R5: Narrowing shifts keep the low S bits of the rounded value and never raise a flag.
- R6: Signed clip clamps the rounded value to [-2^(S-1), 2^(S-1)-1].
- R7: Unsigned clip clamps the rounded value to [0, 2^S-1].
- R8: `sat_o` bit i is set exactly when lane i was clamped. Bits for lanes that do not exist at the selected width are zero.
- R9: Narrow lane i occupies bits [i*S +: S] of a 32-bit group. `hi_sel_i`=0 puts the group in bits 31:0 and zeros bits 63:32. `hi_sel_i`=1 puts it in bits 63:32 and zeros bits 31:0.
- R10: The outputs are a combinational function of the current inputs, with no clock and no retained state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_i | input | 64 | Packed wide source elements |
| shamt_i | input | 64 | Packed per-lane shift amounts |
| op_i | input | 2 | Operation select |
| dw_i | input | 2 | Narrow element width select |
| rm_i | input | 2 | Rounding mode |
| hi_sel_i | input | 1 | Result half select |
| res_o | output | 64 | Packed narrowed result |
| sat_o | output | 4 | Per-lane clamp flags |

## Verification
Every result and every flag is due in the same cycle as its stimulus, zero clock edges later. The bench therefore drives a new input set on a rising edge of its own clock and compares `res_o` and `sat_o` on the following falling edge, once the combinational path has settled. Bench functions compute the expected values from wide integer arithmetic. Constrained random vectors from a fixed seed are mixed with directed rounding ties, clamp boundaries, shift-by-zero cases and the reserved width.

// File: rtl/nclip_pkg.sv
package nclip_pkg;

    typedef enum logic [1:0] {
        OP_NSRL  = 2'd0,
        OP_NSRA  = 2'd1,
        OP_CLIPU = 2'd2,
        OP_CLIPS = 2'd3
    } nclip_op_e;

    typedef enum logic [1:0] {
        DW_8    = 2'd0,
        DW_16   = 2'd1,
        DW_32   = 2'd2,
        DW_RSVD = 2'd3
    } dwidth_e;

    typedef enum logic [1:0] {
        RM_UP    = 2'd0,
        RM_EVEN  = 2'd1,
        RM_TRUNC = 2'd2,
        RM_ODD   = 2'd3
    } rmode_e;

    localparam int unsigned NUM_WIDTHS = 3;
    localparam int unsigned MIN_SRC_W  = 16;

endpackage

// File: rtl/nclip_lane.sv
module nclip_lane
    import nclip_pkg::*;
#(
    parameter int unsigned SRC_W = 16,
    localparam int unsigned DST_W = SRC_W / 2,
    localparam int unsigned SH_W  = $clog2(SRC_W),
    localparam int unsigned EXT_W = SRC_W + 2
) (
    input  logic [SRC_W-1:0] src,
    input  logic [SH_W-1:0]  shamt,
    input  nclip_op_e        op,
    input  rmode_e           rm,
    output logic [DST_W-1:0] narrow,
    output logic             sat
);

    logic                 is_signed;
    logic [EXT_W-1:0]     ext;
    logic [EXT_W-1:0]     shifted;
    logic [EXT_W-1:0]     low_mask;
    logic [EXT_W-1:0]     half_mask;
    logic                 guard;
    logic                 sticky;
    logic                 inc;
    logic [EXT_W-1:0]     rounded;
    logic                 fits_s;
    logic                 fits_u;

    always_comb begin
        is_signed = (op == OP_NSRA) || (op == OP_CLIPS);
        ext       = {{2{is_signed & src[SRC_W-1]}}, src};
        shifted   = EXT_W'($signed(ext) >>> shamt);
        low_mask  = (EXT_W'(1) << shamt) - EXT_W'(1);
        half_mask = low_mask ^ (low_mask >> 1);
        guard     = |(ext & half_mask);
        sticky    = |(ext & (low_mask >> 1));

        unique case (rm)
            RM_UP:    inc = guard;
            RM_EVEN:  inc = guard & (sticky | shifted[0]);
            RM_TRUNC: inc = 1'b0;
            RM_ODD:   inc = ~shifted[0] & (guard | sticky);
            default:  inc = 1'b0;
        endcase

        rounded = shifted + EXT_W'(inc);
        fits_s  = (&rounded[EXT_W-1:DST_W-1]) | ~(|rounded[EXT_W-1:DST_W-1]);
        fits_u  = ~(|rounded[EXT_W-1:DST_W]);

        narrow = rounded[DST_W-1:0];
        sat    = 1'b0;
        unique case (op)
            OP_CLIPS: begin
                if (!fits_s) begin
                    sat    = 1'b1;
                    narrow = rounded[EXT_W-1] ? {1'b1, {(DST_W-1){1'b0}}}
                                              : {1'b0, {(DST_W-1){1'b1}}};
                end
            end
            OP_CLIPU: begin
                if (!fits_u) begin
                    sat    = 1'b1;
                    narrow = '1;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/nclip_lane_array.sv
module nclip_lane_array
    import nclip_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned SRC_W  = 16,
    localparam int unsigned LANES  = DATA_W / SRC_W,
    localparam int unsigned DST_W  = SRC_W / 2,
    localparam int unsigned SH_W   = $clog2(SRC_W),
    localparam int unsigned HALF_W = DATA_W / 2
) (
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] shamt,
    input  nclip_op_e         op,
    input  rmode_e            rm,
    output logic [HALF_W-1:0] narrow,
    output logic [LANES-1:0]  sat
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        nclip_lane #(.SRC_W(SRC_W)) u_lane (
            .src    (src[i*SRC_W +: SRC_W]),
            .shamt  (shamt[i*SRC_W +: SH_W]),
            .op     (op),
            .rm     (rm),
            .narrow (narrow[i*DST_W +: DST_W]),
            .sat    (sat[i])
        );
    end

endmodule

// File: rtl/nclip_pack.sv
module nclip_pack
    import nclip_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    localparam int unsigned HALF_W    = DATA_W / 2,
    localparam int unsigned MAX_LANES = DATA_W / MIN_SRC_W
) (
    input  logic [NUM_WIDTHS-1:0][HALF_W-1:0]    nar,
    input  logic [NUM_WIDTHS-1:0][MAX_LANES-1:0] flg,
    input  dwidth_e                              dw,
    input  logic                                 hi_sel,
    output logic [DATA_W-1:0]                    res,
    output logic [MAX_LANES-1:0]                 sat
);

    logic [HALF_W-1:0] group;
    logic              active;

    always_comb begin
        active = 1'b1;
        unique case (dw)
            DW_8:    begin group = nar[0]; sat = flg[0]; end
            DW_16:   begin group = nar[1]; sat = flg[1]; end
            DW_32:   begin group = nar[2]; sat = flg[2]; end
            default: begin group = '0; sat = '0; active = 1'b0; end
        endcase
        if (!active) begin
            res = '0;
        end else if (hi_sel) begin
            res = {group, {HALF_W{1'b0}}};
        end else begin
            res = {{HALF_W{1'b0}}, group};
        end
    end

endmodule

// File: rtl/nclip_unit.sv
module nclip_unit
    import nclip_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    localparam int unsigned HALF_W    = DATA_W / 2,
    localparam int unsigned MAX_LANES = DATA_W / MIN_SRC_W
) (
    input  logic [DATA_W-1:0]    src_i,
    input  logic [DATA_W-1:0]    shamt_i,
    input  logic [1:0]           op_i,
    input  logic [1:0]           dw_i,
    input  logic [1:0]           rm_i,
    input  logic                 hi_sel_i,
    output logic [DATA_W-1:0]    res_o,
    output logic [MAX_LANES-1:0] sat_o
);

    logic [NUM_WIDTHS-1:0][HALF_W-1:0]    nar;
    logic [NUM_WIDTHS-1:0][MAX_LANES-1:0] flg;

    nclip_op_e op;
    rmode_e    rm;
    dwidth_e   dw;

    assign op = nclip_op_e'(op_i);
    assign rm = rmode_e'(rm_i);
    assign dw = dwidth_e'(dw_i);

    for (genvar k = 0; k < NUM_WIDTHS; k++) begin : g_width
        localparam int unsigned SW = MIN_SRC_W << k;
        localparam int unsigned LN = DATA_W / SW;
        logic [LN-1:0] lane_sat;

        nclip_lane_array #(.DATA_W(DATA_W), .SRC_W(SW)) u_arr (
            .src    (src_i),
            .shamt  (shamt_i),
            .op     (op),
            .rm     (rm),
            .narrow (nar[k]),
            .sat    (lane_sat)
        );

        if (LN < MAX_LANES) begin : g_pad
            assign flg[k] = {{(MAX_LANES-LN){1'b0}}, lane_sat};
        end else begin : g_full
            assign flg[k] = lane_sat;
        end
    end

    nclip_pack #(.DATA_W(DATA_W)) u_pack (
        .nar    (nar),
        .flg    (flg),
        .dw     (dw),
        .hi_sel (hi_sel_i),
        .res    (res_o),
        .sat    (sat_o)
    );

endmodule

// File: rtl/nclip_unit_chk.sv
module nclip_unit_chk #(
    parameter int unsigned DATA_W = 64,
    localparam int unsigned HALF_W    = DATA_W / 2,
    localparam int unsigned MAX_LANES = DATA_W / 16
) (
    input logic [DATA_W-1:0]    src_i,
    input logic [DATA_W-1:0]    shamt_i,
    input logic [1:0]           op_i,
    input logic [1:0]           dw_i,
    input logic [1:0]           rm_i,
    input logic                 hi_sel_i,
    input logic [DATA_W-1:0]    res_o,
    input logic [MAX_LANES-1:0] sat_o
);

    always_comb begin
        // R9
        hi_half_zero_chk: assert (hi_sel_i || res_o[DATA_W-1:HALF_W] == '0);
        // R9
        lo_half_zero_chk: assert (!hi_sel_i || res_o[HALF_W-1:0] == '0);
        // R5
        shift_no_sat_chk: assert (op_i[1] || sat_o == '0);
        // R2
        rsvd_width_chk: assert (dw_i != 2'd3 || (res_o == '0 && sat_o == '0));
        // R8
        lane_flag_range_chk: assert ((dw_i == 2'd0) ||
                                     (dw_i == 2'd1 && sat_o[MAX_LANES-1:2] == '0) ||
                                     (dw_i[1] && sat_o[MAX_LANES-1:1] == '0));
        for (int i = 0; i < 4; i++) begin
            // R6
            clip_s_bound_chk: assert (!(op_i == 2'd3 && dw_i == 2'd0 && sat_o[i]) ||
                res_o[(hi_sel_i ? HALF_W : 0) + 8*i +: 8] == 8'h7F ||
                res_o[(hi_sel_i ? HALF_W : 0) + 8*i +: 8] == 8'h80);
        end
    end

endmodule

bind nclip_unit nclip_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/nclip_unit_tb.sv
module nclip_unit_tb;

    logic        clk = 1'b0;
    logic [63:0] src_i, shamt_i, res_o;
    logic [1:0]  op_i, dw_i, rm_i;
    logic        hi_sel_i;
    logic [3:0]  sat_o;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    nclip_unit u_dut (
        .src_i(src_i), .shamt_i(shamt_i), .op_i(op_i), .dw_i(dw_i),
        .rm_i(rm_i), .hi_sel_i(hi_sel_i), .res_o(res_o), .sat_o(sat_o)
    );

    task automatic model(input logic [63:0] s, input logic [63:0] sh,
                         input logic [1:0] op, input logic [1:0] dw,
                         input logic [1:0] rm, input logic hi,
                         output logic [63:0] er, output logic [3:0] es);
        int nw, ww, lanes, amt, off;
        logic signed [71:0] v, q, rem, half, lo, hi_lim;
        logic [71:0] wmask;
        er = '0; es = '0;
        if (dw == 2'd3) return;
        nw = 8 << dw; ww = 2 * nw; lanes = 64 / ww;
        off = hi ? 32 : 0;
        wmask = (72'd1 << ww) - 72'd1;
        for (int i = 0; i < lanes; i++) begin
            v   = 72'((s >> (i*ww))) & wmask;
            amt = int'((sh >> (i*ww)) & 64'(ww - 1));
            if ((op == 2'd1 || op == 2'd3) && v[ww-1]) v = v | ~wmask;
            q    = v >>> amt;
            rem  = v - (q <<< amt);
            half = (amt > 0) ? (72'sd1 <<< (amt - 1)) : 72'sd0;
            case (rm)
                2'd0: if (amt > 0 && rem >= half) q = q + 1;
                2'd1: if (amt > 0 && (rem > half || (rem == half && q[0]))) q = q + 1;
                2'd3: if (rem != 0) q[0] = 1'b1;
                default: ;
            endcase
            if (op == 2'd3) begin
                hi_lim = (72'sd1 <<< (nw - 1)) - 1;
                lo     = -(72'sd1 <<< (nw - 1));
                if (q > hi_lim) begin q = hi_lim; es[i] = 1'b1; end
                if (q < lo)     begin q = lo;     es[i] = 1'b1; end
            end else if (op == 2'd2) begin
                hi_lim = (72'sd1 <<< nw) - 1;
                if (q > hi_lim) begin q = hi_lim; es[i] = 1'b1; end
            end
            for (int b = 0; b < nw; b++) er[off + i*nw + b] = q[b];
        end
    endtask

    task automatic run(input logic [63:0] s, input logic [63:0] sh,
                       input logic [1:0] op, input logic [1:0] dw,
                       input logic [1:0] rm, input logic hi, input string tag);
        logic [63:0] er;
        logic [3:0]  es;
        @(posedge clk);
        src_i = s; shamt_i = sh; op_i = op; dw_i = dw; rm_i = rm; hi_sel_i = hi;
        model(s, sh, op, dw, rm, hi, er, es);
        @(negedge clk);
        n_checks++;
        if (res_o !== er) begin
            n_errors++;
            $display("FAIL %s result: actual=%h expected=%h (op=%0d dw=%0d rm=%0d hi=%0d)",
                     tag, res_o, er, op, dw, rm, hi);
        end
        n_checks++;
        if (sat_o !== es) begin
            n_errors++;
            $display("FAIL R8 flags (%s): actual=%b expected=%b", tag, sat_o, es);
        end
    endtask

    function automatic string op_tag(input logic [1:0] op);
        return op == 2'd3 ? "R6" : (op == 2'd2 ? "R7" : "R5");
    endfunction

    initial begin
        int unsigned seed;
        logic [63:0] rs, rsh;
        logic [1:0]  rop, rdw, rrm;
        src_i = '0; shamt_i = '0; op_i = '0; dw_i = '0; rm_i = '0; hi_sel_i = 1'b0;
        // R10: zero inputs give zero outputs with no clock involvement
        run(64'h0, 64'h0, 2'd0, 2'd0, 2'd0, 1'b0, "R10");
        // R1: logical vs arithmetic shift of a negative 16-bit source
        run(64'h8000_8000_8000_8000, 64'h0004_0004_0004_0004, 2'd0, 2'd0, 2'd2, 1'b0, "R1");
        run(64'h8000_8000_8000_8000, 64'h0004_0004_0004_0004, 2'd1, 2'd0, 2'd2, 1'b0, "R1");
        // R3: upper bits of the shift slot are ignored
        run(64'h1234_5678_9ABC_DEF0, 64'hFFF3_0013_FF03_0103, 2'd0, 2'd0, 2'd2, 1'b0, "R3");
        run(64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFE5_0000_0105, 2'd1, 2'd1, 2'd2, 1'b1, "R3");
        // R4: tie cases under each mode (value 0x0006 >> 2 = 1.5, 0x000A >> 2 = 2.5)
        for (int m = 0; m < 4; m++) begin
            run(64'h0006_000A_0005_0007, 64'h0002_0002_0002_0002, 2'd0, 2'd0, 2'(m), 1'b0, "R4");
        end
        // R4: shift of zero never rounds
        run(64'h0000_0000_FFFF_FFFF, 64'h0, 2'd0, 2'd2, 2'd3, 1'b0, "R4");
        // R6: signed clip at both bounds, 8-bit result
        run(64'h7FFF_8000_007F_FF80, 64'h0, 2'd3, 2'd0, 2'd0, 1'b0, "R6");
        run(64'h00FF_FF00_0080_FF7F, 64'h0001_0001_0000_0000, 2'd3, 2'd0, 2'd0, 1'b1, "R6");
        // R6: 32-bit result from the full word
        run(64'h8000_0000_0000_0001, 64'h0, 2'd3, 2'd2, 2'd2, 1'b0, "R6");
        // R7: unsigned clip at the bound and just beyond; rounding carries over
        run(64'h00FF_0100_FFFF_01FF, 64'h0000_0000_0008_0001, 2'd2, 2'd0, 2'd0, 1'b0, "R7");
        run(64'h0001_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0010, 2'd2, 2'd1, 2'd0, 1'b1, "R7");
        // R2: reserved width
        run(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 2'd3, 2'd3, 2'd0, 1'b1, "R2");
        // R9: both halves with the same data
        run(64'hA5A5_5A5A_C3C3_3C3C, 64'h0001_0002_0003_0004, 2'd0, 2'd0, 2'd1, 1'b0, "R9");
        run(64'hA5A5_5A5A_C3C3_3C3C, 64'h0001_0002_0003_0004, 2'd0, 2'd0, 2'd1, 1'b1, "R9");

        seed = $urandom(32'd20240611);
        for (int n = 0; n < 600; n++) begin
            rs  = {$urandom, $urandom};
            rsh = {$urandom, $urandom};
            rop = 2'($urandom);
            rdw = 2'($urandom_range(0, 15) == 0 ? 3 : $urandom_range(0, 2));
            rrm = 2'($urandom);
            if (n % 3 == 0) rsh = rsh & 64'h0003_0003_0003_0003;
            run(rs, rsh, rop, rdw, rrm, 1'($urandom), op_tag(rop));
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule